// File: doc/BRIEF.md
# Reset Source Controller with Boot Vector Selection

This block gathers six reset requests and turns them into one synchronous, active-high core reset: a shared low-active pin, power-on detect, brownout detect, watchdog timeout, a software reset command and a UART break-detect pulse. Each request passes through a two-stage synchroniser. The core reset is held for a fixed number of cycles after the last request goes away.

A six-bit cause register records which sources produced resets. Power-on and watchdog resets load a fixed pattern into it. All other resets add their own bit to what is already there. Software clears bits by writing zeros, and writing ones has no effect. The block also chooses the post-reset fetch address, either 0000h or a boot address whose high byte is an 8-bit boot vector. The shared pin serves as a reset input or as a plain digital input, depending on a configuration bit. During power-up it always acts as a reset input.

Top module: `reset_cause_ctrl`

## Requirements
- R1: While rst_ni is low, core_rst_o is 1 and flags_o reads 00h.
- R2: A request asserted just after a clock edge raises core_rst_o after the third following rising edge, and not before. This covers two synchroniser stages and one load stage.
- R3: After the last request deasserts, core_rst_o stays 1 through the fifth rising edge and is 0 after the sixth. That is the two synchroniser edges plus 4 hold cycles.
- R4: With pin_rst_en_i = 1, a low level on pin_n_i asserts core_rst_o and sets flag bit 0 (external).
- R5: With pin_rst_en_i = 0 and no power-up in progress, a low pin_n_i neither resets nor sets any flag. pin_gpio_o follows pin_n_i two edges later.
- R6: While power-on is requested, and until the core reset that follows it ends, a low pin_n_i acts as a reset and sets bit 0 whatever pin_rst_en_i is. After that window, the configuration bit governs the pin again.
- R7: A power-on reset leaves flags_o = 06h: bit 1 (power-on) and bit 2 (brownout) set, all others cleared.
- R8: A watchdog reset also leaves flags_o = 06h. Bit 3 (watchdog) ends up 0.
- R9: A brownout, software (bit 4), UART-break (bit 5) or external reset sets its own bit and keeps every earlier flag.
- R10: A write with flag_we_i = 1 clears each bit where flag_wdata_i is 0. Ones leave their bits unchanged, and bits 7:6 always read 0.
- R11: If other sources rise in the same cycle as a power-on or watchdog request, the fixed pattern is applied and those other sources' bits are also set. Power-on with software gives 16h. Watchdog with UART break gives 26h.
- R12: fetch_addr_o is {boot_vec_i, 00h} in any of three cases: the last reset event had a UART break active, the last reset event had power-on active with isp_force_i = 1, or boot_stat0_i = 1. Otherwise it is 0000h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low register reset |
| pin_n_i | input | 1 | Shared pin, low-active reset when enabled |
| pin_rst_en_i | input | 1 | 1: pin is a reset input; 0: digital input only |
| por_i | input | 1 | Power-on detect request |
| bod_i | input | 1 | Brownout detect request |
| wdt_i | input | 1 | Watchdog timeout request |
| swr_i | input | 1 | Software reset request |
| brk_i | input | 1 | UART break-detect request |
| isp_force_i | input | 1 | Forced programming-mode entry, sampled at power-on |
| boot_stat0_i | input | 1 | Non-volatile boot status bit 0 |
| boot_vec_i | input | 8 | Boot vector (high byte of boot address) |
| flag_we_i | input | 1 | Cause register write strobe |
| flag_wdata_i | input | 8 | Write data; a 0 bit clears that flag |
| flags_o | output | 8 | Cause flags: b0 ext, b1 por, b2 bod, b3 wdt, b4 sw, b5 break |
| pin_gpio_o | output | 1 | Synchronised pin level |
| core_rst_o | output | 1 | Active-high core reset |
| fetch_addr_o | output | 16 | Post-reset fetch address |

## Verification
Faults in the synchroniser or the hold counter move the rise or fall of core_rst_o by one or more edges. These show up at once in the edge-exact latency checks. A lost edge-detect or a wrong fixed pattern in the cause register is visible in flags_o a few cycles after the triggering reset. A wrongly kept power-up window or a stale boot cause stays hidden until the next pin event or reset event. The scenarios therefore follow each such transition with a stimulus that exposes it, such as a pin pulse with the configuration bit off, or a software reset after a break.

// File: rtl/rcc_pkg.sv
package rcc_pkg;
  localparam int N_SRC   = 6;
  localparam int SRC_EXT = 0;
  localparam int SRC_POR = 1;
  localparam int SRC_BOD = 2;
  localparam int SRC_WDT = 3;
  localparam int SRC_SWR = 4;
  localparam int SRC_BRK = 5;

  typedef logic [N_SRC-1:0] src_vec_t;

  localparam src_vec_t PWR_TRIG = src_vec_t'((1 << SRC_POR) | (1 << SRC_WDT));
  localparam src_vec_t PWR_SET  = src_vec_t'((1 << SRC_POR) | (1 << SRC_BOD));
  localparam src_vec_t PWR_KEEP = ~src_vec_t'(1 << SRC_WDT);
endpackage

// File: rtl/rcc_sync.sv
module rcc_sync #(
  parameter int       W       = 6,
  parameter int       STAGES  = 2,
  parameter bit [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q[0] <= RST_VAL;
    else         stg_q[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[s] <= RST_VAL;
      else         stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/rcc_stretch.sv
module rcc_stretch #(
  parameter int HOLD = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  output logic active_o
);
  localparam int CW = $clog2(HOLD + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= CW'(HOLD);
    else if (req_i)         cnt_q <= CW'(HOLD);
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign active_o = (cnt_q != '0);

  assert_count_down_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!req_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/rcc_flags.sv
module rcc_flags
  import rcc_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  src_vec_t req_i,
  input  logic     we_i,
  input  src_vec_t wdata_i,
  output src_vec_t flags_o,
  output src_vec_t ev_o
);
  src_vec_t req_q, flags_q, flags_d, ev;

  assign ev = req_i & ~req_q;

  always_comb begin
    if ((ev & PWR_TRIG) != '0) begin
      flags_d = PWR_SET | (ev & PWR_KEEP);
    end else begin
      flags_d = (we_i ? (flags_q & wdata_i) : flags_q) | ev;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q   <= '0;
      flags_q <= '0;
    end else begin
      req_q   <= req_i;
      flags_q <= flags_d;
    end
  end

  assign flags_o = flags_q;
  assign ev_o    = ev;

  assert_pwr_pattern_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev[SRC_POR] || ev[SRC_WDT]) |=>
      (flags_q[SRC_POR] && flags_q[SRC_BOD] && !flags_q[SRC_WDT]));

  assert_no_spurious_set_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev == '0) |=> ((flags_q & ~$past(flags_q)) == '0));

  assert_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!we_i && !ev[SRC_POR] && !ev[SRC_WDT]) |=>
      ((flags_q & $past(flags_q)) == $past(flags_q)));
endmodule

// File: rtl/rcc_boot_sel.sv
module rcc_boot_sel #(
  parameter int VEC_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             event_i,
  input  logic             brk_i,
  input  logic             por_i,
  input  logic             isp_i,
  input  logic             stat0_i,
  input  logic [VEC_W-1:0] vec_i,
  output logic [VEC_W+7:0] addr_o
);
  logic cause_q;

  // cause is re-evaluated on every new reset event
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cause_q <= 1'b0;
    else if (event_i) cause_q <= brk_i | (por_i & isp_i);
  end

  assign addr_o = (cause_q || stat0_i) ? {vec_i, 8'h00} : '0;
endmodule

// File: rtl/reset_cause_ctrl.sv
module reset_cause_ctrl
  import rcc_pkg::*;
#(
  parameter int HOLD_CYCLES = 4,
  parameter int SYNC_STAGES = 2,
  parameter int VEC_W       = 8,
  parameter int REG_W       = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pin_n_i,
  input  logic             pin_rst_en_i,
  input  logic             por_i,
  input  logic             bod_i,
  input  logic             wdt_i,
  input  logic             swr_i,
  input  logic             brk_i,
  input  logic             isp_force_i,
  input  logic             boot_stat0_i,
  input  logic [VEC_W-1:0] boot_vec_i,
  input  logic             flag_we_i,
  input  logic [REG_W-1:0] flag_wdata_i,
  output logic [REG_W-1:0] flags_o,
  output logic             pin_gpio_o,
  output logic             core_rst_o,
  output logic [VEC_W+7:0] fetch_addr_o
);
  localparam src_vec_t SYNC_RST = src_vec_t'(1 << SRC_EXT);

  src_vec_t raw, sync_q, req, flags, ev;
  logic     pin_s, por_s, pwr_up, ext_req, any_req, por_phase_q;

  // bit SRC_EXT carries the raw pin level; other bits are the requests
  assign raw = {brk_i, swr_i, wdt_i, bod_i, por_i, pin_n_i};

  rcc_sync #(.W(N_SRC), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw),
    .q_o   (sync_q)
  );

  assign pin_s   = sync_q[SRC_EXT];
  assign por_s   = sync_q[SRC_POR];
  assign pwr_up  = por_s | por_phase_q;
  assign ext_req = ~pin_s & (pin_rst_en_i | pwr_up);

  always_comb begin
    req          = sync_q;
    req[SRC_EXT] = ext_req;
  end

  assign any_req = |req;

  // power-up window: from power-on request until the core reset ends
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) por_phase_q <= 1'b1;
    else         por_phase_q <= por_s | (por_phase_q & core_rst_o);
  end

  rcc_stretch #(.HOLD(HOLD_CYCLES)) u_stretch (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (any_req),
    .active_o(core_rst_o)
  );

  rcc_flags u_flags (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (req),
    .we_i   (flag_we_i),
    .wdata_i(flag_wdata_i[N_SRC-1:0]),
    .flags_o(flags),
    .ev_o   (ev)
  );

  rcc_boot_sel #(.VEC_W(VEC_W)) u_boot (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .event_i(|ev),
    .brk_i  (req[SRC_BRK]),
    .por_i  (req[SRC_POR]),
    .isp_i  (isp_force_i),
    .stat0_i(boot_stat0_i),
    .vec_i  (boot_vec_i),
    .addr_o (fetch_addr_o)
  );

  assign flags_o    = {{(REG_W-N_SRC){1'b0}}, flags};
  assign pin_gpio_o = pin_s;

  assert_req_resets_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_req |=> core_rst_o);

  assert_brk_boot_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req[SRC_BRK] |=> (fetch_addr_o == {boot_vec_i, 8'h00}));

  assert_pwr_pin_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (por_s && !pin_s) |=> core_rst_o);
endmodule

// File: tb/reset_cause_ctrl_test.sv
module reset_cause_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        pin_n = 1'b1, pin_en = 1'b0;
  logic        por = 1'b1, bod = 1'b0, wdt = 1'b0, swr = 1'b0, brk = 1'b0;
  logic        isp = 1'b0, bstat = 1'b0;
  logic [7:0]  bvec = 8'hA5;
  logic        we = 1'b0;
  logic [7:0]  wdata = 8'hFF;
  logic [7:0]  flags;
  logic        gpio, core_rst;
  logic [15:0] faddr;
  int          checks = 0, errors = 0;

  always #10 clk = ~clk;

  reset_cause_ctrl uut (
    .clk_i(clk), .rst_ni(rst_ni), .pin_n_i(pin_n), .pin_rst_en_i(pin_en),
    .por_i(por), .bod_i(bod), .wdt_i(wdt), .swr_i(swr), .brk_i(brk),
    .isp_force_i(isp), .boot_stat0_i(bstat), .boot_vec_i(bvec),
    .flag_we_i(we), .flag_wdata_i(wdata), .flags_o(flags),
    .pin_gpio_o(gpio), .core_rst_o(core_rst), .fetch_addr_o(faddr)
  );

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr_flags(logic [7:0] d);
    wdata = d; we = 1'b1;
    tick(1);
    we = 1'b0; wdata = 8'hFF;
  endtask

  task automatic t_reset;
    tick(3);
    chk("R1 core_rst in reset", core_rst, 1);
    chk("R1 flags in reset", flags, 8'h00);
    rst_ni = 1'b1;
    tick(10);
    por = 1'b0;
    tick(12);
    chk("R7 flags after power-on", flags, 8'h06);
    chk("R7 core_rst released", core_rst, 0);
  endtask

  task automatic t_latency;
    swr = 1'b1;
    tick(1); chk("R2 edge1", core_rst, 0);
    tick(1); chk("R2 edge2", core_rst, 0);
    tick(1); chk("R2 edge3", core_rst, 1);
    tick(3);
    swr = 1'b0;
    tick(5); chk("R3 held after 5 edges", core_rst, 1);
    tick(1); chk("R3 low after 6 edges", core_rst, 0);
    chk("R9 software flag added", flags, 8'h16);
  endtask

  task automatic t_clear;
    wr_flags(8'hFF); chk("R10 write ones no effect", flags, 8'h16);
    wr_flags(8'hEF); chk("R10 clear bit4", flags, 8'h06);
    wr_flags(8'hC0); chk("R10 clear all, 7:6 zero", flags, 8'h00);
  endtask

  task automatic pulse(ref logic s);
    s = 1'b1; tick(3); s = 1'b0; tick(10);
  endtask

  task automatic t_accum;
    pulse(bod); chk("R9 brownout", flags, 8'h04);
    pulse(brk); chk("R9 break keeps brownout", flags, 8'h24);
    pulse(swr); chk("R9 software keeps others", flags, 8'h34);
  endtask

  task automatic t_wdt;
    pulse(wdt); chk("R8 watchdog pattern", flags, 8'h06);
  endtask

  task automatic t_pin_en;
    wr_flags(8'h00);
    pin_en = 1'b1; pin_n = 1'b0;
    tick(4); chk("R4 pin reset active", core_rst, 1);
    pin_n = 1'b1;
    tick(10);
    chk("R4 external flag", flags, 8'h01);
    chk("R4 core_rst released", core_rst, 0);
  endtask

  task automatic t_pin_dis;
    wr_flags(8'h00);
    pin_en = 1'b0; pin_n = 1'b0;
    tick(1); chk("R5 gpio after 1 edge", gpio, 1);
    tick(1); chk("R5 gpio after 2 edges", gpio, 0);
    tick(8);
    chk("R5 no reset", core_rst, 0);
    chk("R5 no flag", flags, 8'h00);
    pin_n = 1'b1;
    tick(3); chk("R5 gpio high", gpio, 1);
  endtask

  task automatic t_pwr_override;
    pin_en = 1'b0;
    por = 1'b1; pin_n = 1'b0;
    tick(4); por = 1'b0;
    tick(10); chk("R6 pin holds reset after power-on", core_rst, 1);
    pin_n = 1'b1;
    tick(10);
    chk("R6 released", core_rst, 0);
    chk("R6 flags", flags, 8'h07);
    wr_flags(8'h00);
    pin_n = 1'b0;
    tick(10);
    chk("R6 window over, pin ignored", core_rst, 0);
    chk("R6 window over, no flag", flags, 8'h00);
    pin_n = 1'b1;
    tick(3);
  endtask

  task automatic t_simul;
    wr_flags(8'h00);
    por = 1'b1; swr = 1'b1; tick(3); por = 1'b0; swr = 1'b0; tick(10);
    chk("R11 power-on with software", flags, 8'h16);
    wr_flags(8'h00);
    wdt = 1'b1; brk = 1'b1; tick(3); wdt = 1'b0; brk = 1'b0; tick(10);
    chk("R11 watchdog with break", flags, 8'h26);
  endtask

  task automatic t_boot;
    chk("R12 boot after break", faddr, 16'hA500);
    pulse(swr); chk("R12 zero after software reset", faddr, 16'h0000);
    bstat = 1'b1; tick(1); chk("R12 boot status", faddr, 16'hA500);
    bstat = 1'b0; tick(1); chk("R12 boot status off", faddr, 16'h0000);
    isp = 1'b1; pulse(por); isp = 1'b0; tick(1);
    chk("R12 forced entry at power-on", faddr, 16'hA500);
    pulse(swr); chk("R12 cleared by later reset", faddr, 16'h0000);
  endtask

  initial begin
    tick(200000);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_latency();
    t_clear();
    t_accum();
    t_wdt();
    t_pin_en();
    t_pin_dis();
    t_pwr_override();
    t_simul();
    t_boot();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule